// File: doc/BRIEF.md
# Packed String Compare Unit

This unit compares two 128-bit vectors of packed characters and turns the result into a per-element bit mask. Operand A holds a set of characters, a needle or a list of bound pairs. Operand B is the text that is scanned. Each operand has its own valid-length count. Characters are either 8-bit (sixteen per operand) or 16-bit (eight per operand), and all comparisons are unsigned.

Every B element is compared with every A element, which gives a square array of equality and bound results. A 2-bit mode select chooses how that array is reduced:

- its diagonal (position-wise equality),
- an OR over each B element's row (set membership),
- pairs of bound checks (range test),
- an AND along each slanted diagonal (substring start).

Alongside the mask the unit reports the index of the lowest set mask bit and a flag that is high when the mask is empty. A request presented with `in_valid` produces a registered result one clock later. The result holds while no new request arrives.

Top module: `pstr_cmp_unit`

## Requirements
- R1: With `word_mode`=0, element k is bits [8k+7:8k] and there are 16 lanes. With `word_mode`=1, element k is bits [16k+15:16k] and there are 8 lanes, and mask bits 15:8 are 0. A length count above the lane count is treated as the lane count.
- R2: With `agg_mode`=2'b00 (position equality), mask bit i is 1 when A[i] and B[i] are both valid and equal. It is also 1 when both are invalid. It is 0 when exactly one of the two is valid.
- R3: With `agg_mode`=2'b01 (set membership), mask bit i is 1 when B[i] is valid and equals some valid A element.
- R4: With `agg_mode`=2'b11 (substring start), mask bit i is 1 when B[i] is valid and B[i+j] equals A[j] for every valid A[j] with i+j inside B's valid length. Needle elements that fall past B's end count as matches, so a partial match at the tail is reported. An empty needle marks every valid B position.
- R5: With `agg_mode`=2'b10 (range test), A holds bound pairs: A[2k] is the low bound and A[2k+1] the high bound. Mask bit i is 1 when B[i] is valid and, for some pair whose two elements are both valid, low ≤ B[i] ≤ high.
- R6: In set-membership, range and substring modes, mask bits of invalid B positions are 0. Invalid A elements never produce a match in set-membership or range mode.
- R7: `first_idx` is the lowest set mask bit. When the mask is all zero, `first_idx` equals the lane count (16 or 8) and `mask_zero` is 1; otherwise `mask_zero` is 0.
- R8: The result of a request with `in_valid`=1 appears on the outputs one clock later with `out_valid`=1. In a cycle after `in_valid`=0, `out_valid` is 0 and `mask`, `first_idx` and `mask_zero` keep their previous values.
- R9: After reset, `out_valid`, `mask`, `first_idx` and `mask_zero` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 128 | Set, needle or bound pairs |
| op_b | input | 128 | Text scanned |
| word_mode | input | 1 | 0: 8-bit elements, 1: 16-bit elements |
| agg_mode | input | 2 | 00 equal-each, 01 equal-any, 10 ranges, 11 ordered |
| len_a | input | 5 | Valid element count of op_a |
| len_b | input | 5 | Valid element count of op_b |
| out_valid | output | 1 | Result strobe |
| mask | output | 16 | Per-element result |
| first_idx | output | 5 | Lowest set mask bit or lane count |
| mask_zero | output | 1 | Mask is empty |

## Verification
The assertions check on every cycle that:
- the index, the empty flag and the mask agree with each other;
- the upper lanes stay clear in 16-bit mode;
- the valid strobe follows the request one cycle later;
- outputs hold between requests.

Only the bench's scenarios can show that each mask is correct for its mode. These cover:
- the diagonal, row-OR and slanted-AND reductions;
- the bound-pair tests;
- the invalid-lane rules;
- length clamping;
- partial tail matches.

The bench checks all of these against a loop-based model, both for directed strings and for random operands drawn from a small alphabet.

// File: rtl/pstr_pkg.sv
package pstr_pkg;
    typedef enum logic [1:0] {
        AGG_EACH  = 2'b00,
        AGG_ANY   = 2'b01,
        AGG_RANGE = 2'b10,
        AGG_ORDER = 2'b11
    } agg_e;
endpackage

// File: rtl/pstr_unpack.sv
module pstr_unpack #(
    parameter int ELEM_BITS = 8,
    parameter int LANES     = 16,
    localparam int OP_W  = ELEM_BITS * LANES,
    localparam int EW    = 2 * ELEM_BITS,
    localparam int HALF  = LANES / 2,
    localparam int IDX_W = $clog2(LANES + 1)
) (
    input  logic [OP_W-1:0]            op,
    input  logic                       word_mode,
    input  logic [IDX_W-1:0]           len,
    output logic [LANES-1:0][EW-1:0]   elem,
    output logic [LANES-1:0]           valid,
    output logic [LANES-1:0]           lane_on
);
    logic [IDX_W-1:0] cnt;
    logic [IDX_W-1:0] eff_len;

    assign cnt     = word_mode ? IDX_W'(HALF) : IDX_W'(LANES);
    assign eff_len = (len > cnt) ? cnt : len;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [EW-1:0] narrow;
        assign narrow = {{(EW-ELEM_BITS){1'b0}}, op[ELEM_BITS*k +: ELEM_BITS]};
        if (k < HALF) begin : g_lo
            assign elem[k] = word_mode ? op[EW*k +: EW] : narrow;
        end else begin : g_hi
            assign elem[k] = word_mode ? '0 : narrow;
        end
        assign valid[k]   = IDX_W'(k) < eff_len;
        assign lane_on[k] = IDX_W'(k) < cnt;
    end
endmodule

// File: rtl/pstr_matrix.sv
module pstr_matrix #(
    parameter int ELEM_BITS = 8,
    parameter int LANES     = 16,
    localparam int EW   = 2 * ELEM_BITS,
    localparam int HALF = LANES / 2
) (
    input  logic [LANES-1:0][EW-1:0]    a_el,
    input  logic [LANES-1:0][EW-1:0]    b_el,
    output logic [LANES-1:0][LANES-1:0] eq,
    output logic [LANES-1:0][HALF-1:0]  lo_ok,
    output logic [LANES-1:0][HALF-1:0]  hi_ok
);
    for (genvar i = 0; i < LANES; i++) begin : g_row
        for (genvar j = 0; j < LANES; j++) begin : g_col
            assign eq[i][j] = (b_el[i] == a_el[j]);
        end
        for (genvar p = 0; p < HALF; p++) begin : g_pair
            assign lo_ok[i][p] = (b_el[i] >= a_el[2*p]);
            assign hi_ok[i][p] = (b_el[i] <= a_el[2*p+1]);
        end
    end
endmodule

// File: rtl/pstr_reduce.sv
module pstr_reduce
    import pstr_pkg::*;
#(
    parameter int LANES = 16,
    localparam int HALF = LANES / 2
) (
    input  agg_e                        mode,
    input  logic [LANES-1:0][LANES-1:0] eq,
    input  logic [LANES-1:0][HALF-1:0]  lo_ok,
    input  logic [LANES-1:0][HALF-1:0]  hi_ok,
    input  logic [LANES-1:0]            va,
    input  logic [LANES-1:0]            vb,
    input  logic [LANES-1:0]            lane_on,
    output logic [LANES-1:0]            mask
);
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic bit_v;
            bit_v = 1'b0;
            unique case (mode)
                AGG_EACH: begin
                    if (va[i] && vb[i]) bit_v = eq[i][i];
                    else                bit_v = !va[i] && !vb[i];
                end
                AGG_ANY: begin
                    for (int j = 0; j < LANES; j++)
                        if (va[j] && eq[i][j]) bit_v = 1'b1;
                    bit_v = bit_v && vb[i];
                end
                AGG_RANGE: begin
                    for (int p = 0; p < HALF; p++)
                        if (va[2*p] && va[2*p+1] && lo_ok[i][p] && hi_ok[i][p])
                            bit_v = 1'b1;
                    bit_v = bit_v && vb[i];
                end
                AGG_ORDER: begin
                    bit_v = vb[i];
                    for (int j = 0; j < LANES; j++) begin
                        if (va[j] && (i + j < LANES)) begin
                            if (vb[i+j] && !eq[i+j][j]) bit_v = 1'b0;
                        end
                    end
                end
                default: bit_v = 1'b0;
            endcase
            mask[i] = bit_v && lane_on[i];
        end
    end
endmodule

// File: rtl/pstr_first.sv
module pstr_first #(
    parameter int LANES = 16,
    localparam int IDX_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] mask,
    input  logic [IDX_W-1:0] cnt,
    output logic [IDX_W-1:0] idx,
    output logic             none
);
    always_comb begin
        idx = cnt;
        for (int k = LANES - 1; k >= 0; k--)
            if (mask[k]) idx = IDX_W'(k);
        none = (mask == '0);
    end
endmodule

// File: rtl/pstr_cmp_unit.sv
module pstr_cmp_unit
    import pstr_pkg::*;
#(
    parameter int ELEM_BITS = 8,
    parameter int LANES     = 16,
    localparam int OP_W  = ELEM_BITS * LANES,
    localparam int EW    = 2 * ELEM_BITS,
    localparam int HALF  = LANES / 2,
    localparam int IDX_W = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic             word_mode,
    input  logic [1:0]       agg_mode,
    input  logic [IDX_W-1:0] len_a,
    input  logic [IDX_W-1:0] len_b,
    output logic             out_valid,
    output logic [LANES-1:0] mask,
    output logic [IDX_W-1:0] first_idx,
    output logic             mask_zero
);
    typedef struct packed {
        logic             vld;
        logic             wide;
        logic [LANES-1:0] mask;
        logic [IDX_W-1:0] idx;
        logic             zero;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0][EW-1:0]    a_el, b_el;
    logic [LANES-1:0]            va, vb, lane_on, lane_on_b;
    logic [LANES-1:0][LANES-1:0] eq;
    logic [LANES-1:0][HALF-1:0]  lo_ok, hi_ok;
    logic [LANES-1:0]            mask_c;
    logic [IDX_W-1:0]            idx_c, cnt_c;
    logic                        none_c;

    pstr_unpack #(.ELEM_BITS(ELEM_BITS), .LANES(LANES)) u_unpack_a (
        .op(op_a), .word_mode(word_mode), .len(len_a),
        .elem(a_el), .valid(va), .lane_on(lane_on)
    );

    pstr_unpack #(.ELEM_BITS(ELEM_BITS), .LANES(LANES)) u_unpack_b (
        .op(op_b), .word_mode(word_mode), .len(len_b),
        .elem(b_el), .valid(vb), .lane_on(lane_on_b)
    );

    pstr_matrix #(.ELEM_BITS(ELEM_BITS), .LANES(LANES)) u_matrix (
        .a_el(a_el), .b_el(b_el), .eq(eq), .lo_ok(lo_ok), .hi_ok(hi_ok)
    );

    pstr_reduce #(.LANES(LANES)) u_reduce (
        .mode(agg_e'(agg_mode)), .eq(eq), .lo_ok(lo_ok), .hi_ok(hi_ok),
        .va(va), .vb(vb), .lane_on(lane_on & lane_on_b), .mask(mask_c)
    );

    assign cnt_c = word_mode ? IDX_W'(HALF) : IDX_W'(LANES);

    pstr_first #(.LANES(LANES)) u_first (
        .mask(mask_c), .cnt(cnt_c), .idx(idx_c), .none(none_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.wide = word_mode;
            st_d.mask = mask_c;
            st_d.idx  = idx_c;
            st_d.zero = none_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign mask      = st_q.mask;
    assign first_idx = st_q.idx;
    assign mask_zero = st_q.zero;

    assert_req_to_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_no_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(mask) && $stable(first_idx) && $stable(mask_zero)));
    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mask_zero == (mask == '0)));
    assert_idx_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mask_zero) |->
            (mask[first_idx] && ((mask & ((LANES'(1) << first_idx) - LANES'(1))) == '0)));
    assert_idx_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mask_zero) |->
            (first_idx == (st_q.wide ? IDX_W'(HALF) : IDX_W'(LANES))));
    assert_upper_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.wide) |-> (mask[LANES-1:HALF] == '0));
endmodule

// File: tb/tb_pstr_cmp_unit.sv
`timescale 1ns/1ps
module tb_pstr_cmp_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] op_a = '0, op_b = '0;
    logic         word_mode = 1'b0;
    logic [1:0]   agg_mode = 2'b00;
    logic [4:0]   len_a = '0, len_b = '0;
    logic         out_valid;
    logic [15:0]  mask;
    logic [4:0]   first_idx;
    logic         mask_zero;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pstr_cmp_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .word_mode(word_mode), .agg_mode(agg_mode), .len_a(len_a), .len_b(len_b),
        .out_valid(out_valid), .mask(mask), .first_idx(first_idx), .mask_zero(mask_zero)
    );

    function automatic logic [127:0] pack_str(input string s);
        logic [127:0] r = '0;
        for (int k = 0; k < s.len() && k < 16; k++) r[8*k +: 8] = s[k];
        return r;
    endfunction

    function automatic logic [15:0] el(input logic [127:0] op, input int k, input logic wm);
        if (wm) return op[16*k +: 16];
        return {8'h00, op[8*k +: 8]};
    endfunction

    function automatic logic [15:0] ref_mask(input logic [127:0] a, input logic [127:0] b,
                                             input logic wm, input logic [1:0] md,
                                             input int la, input int lb);
        int n = wm ? 8 : 16;
        int ea = (la > n) ? n : la;
        int eb = (lb > n) ? n : lb;
        logic [15:0] r = '0;
        for (int i = 0; i < n; i++) begin
            logic v = 1'b0;
            case (md)
                2'b00: begin
                    if (i < ea && i < eb) v = (el(a, i, wm) == el(b, i, wm));
                    else v = (i >= ea && i >= eb);
                end
                2'b01: if (i < eb)
                    for (int j = 0; j < ea; j++) if (el(a, j, wm) == el(b, i, wm)) v = 1'b1;
                2'b10: if (i < eb)
                    for (int p = 0; 2*p+1 < ea; p++)
                        if (el(a, 2*p, wm) <= el(b, i, wm) && el(b, i, wm) <= el(a, 2*p+1, wm))
                            v = 1'b1;
                default: if (i < eb) begin
                    v = 1'b1;
                    for (int j = 0; j < ea; j++)
                        if (i + j < eb && el(b, i+j, wm) != el(a, j, wm)) v = 1'b0;
                end
            endcase
            r[i] = v;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic [127:0] a, input logic [127:0] b,
                       input logic wm, input logic [1:0] md, input int la, input int lb);
        logic [15:0] em;
        logic [4:0]  ei;
        int n = wm ? 8 : 16;
        op_a = a; op_b = b; word_mode = wm; agg_mode = md;
        len_a = 5'(la); len_b = 5'(lb); in_valid = 1'b1;
        @(negedge clk);
        em = ref_mask(a, b, wm, md, la, lb);
        ei = 5'(n);
        for (int k = n - 1; k >= 0; k--) if (em[k]) ei = 5'(k);
        chk({tag, " R8 out_valid"}, 32'(out_valid), 32'd1);
        chk({tag, " mask"}, 32'(mask), 32'(em));
        chk({tag, " R7 first_idx"}, 32'(first_idx), 32'(ei));
        chk({tag, " R7 mask_zero"}, 32'(mask_zero), 32'(em == 16'h0));
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R9 out_valid", 32'(out_valid), 0);
        chk("R9 mask", 32'(mask), 0);
        chk("R9 first_idx", 32'(first_idx), 0);
        chk("R9 mask_zero", 32'(mask_zero), 0);
        rst_n = 1'b1;

        run("R4 needle at 1", pack_str("ABC"), pack_str("XABCYABZ"), 0, 2'b11, 3, 8);
        chk("R4 needle at 1 exact", 32'(mask), 32'h0002);
        run("R4 tail partial", pack_str("AB"), pack_str("QQQQQQA"), 0, 2'b11, 2, 7);
        chk("R4 tail partial exact", 32'(mask), 32'h0040);
        run("R4 empty needle", pack_str("Z"), pack_str("abcde"), 0, 2'b11, 0, 5);
        chk("R4 empty needle exact", 32'(mask), 32'h001F);
        run("R2 each", pack_str("Test"), pack_str("Tesx"), 0, 2'b00, 4, 4);
        chk("R2 each exact", 32'(mask), 32'hFFF7);
        run("R2 one invalid", pack_str("ab"), pack_str("ab"), 0, 2'b00, 1, 2);
        chk("R2 one invalid exact", 32'(mask), 32'hFFFD);
        run("R3 any", pack_str("aeiou"), pack_str("banana"), 0, 2'b01, 5, 6);
        chk("R3 any exact", 32'(mask), 32'h002A);
        run("R6 any invalid b", pack_str("a"), pack_str("aaaa"), 0, 2'b01, 1, 2);
        chk("R6 any invalid b exact", 32'(mask), 32'h0003);
        run("R5 ranges", pack_str("AZ09"), pack_str("k7Q!"), 0, 2'b10, 4, 4);
        chk("R5 ranges exact", 32'(mask), 32'h0006);
        run("R5 half pair ignored", pack_str("AZ0"), pack_str("k7Q!"), 0, 2'b10, 3, 4);
        chk("R5 half pair exact", 32'(mask), 32'h0004);
        run("R1 word clamp", {8{16'hBEEF}}, {8{16'hBEEF}}, 1, 2'b00, 31, 31);
        chk("R1 word clamp exact", 32'(mask), 32'h00FF);
        run("R1 word diff high byte", {8{16'h1141}}, {8{16'h2241}}, 1, 2'b01, 8, 8);
        chk("R1 word high byte exact", 32'(mask), 32'h0000);
        chk("R7 word empty idx", 32'(first_idx), 32'd8);
        run("R1 byte clamp", pack_str("abcdefghijklmnop"), pack_str("abcdefghijklmnop"),
            0, 2'b00, 20, 17);
        chk("R1 byte clamp exact", 32'(mask), 32'hFFFF);
        run("R7 empty byte", pack_str("x"), pack_str("abc"), 0, 2'b01, 0, 3);
        chk("R7 empty byte idx", 32'(first_idx), 32'd16);

        held = mask;
        op_a = pack_str("q"); op_b = pack_str("qqqq"); agg_mode = 2'b01;
        len_a = 5'd1; len_b = 5'd4; in_valid = 1'b0;
        @(negedge clk);
        chk("R8 idle out_valid", 32'(out_valid), 0);
        chk("R8 idle mask held", 32'(mask), 32'(held));
        chk("R8 idle idx held", 32'(first_idx), 32'd16);

        for (int it = 0; it < 400; it++) begin
            logic [127:0] a, b;
            logic [1:0] md = 2'($urandom % 4);
            logic wm = 1'($urandom % 2);
            for (int k = 0; k < 16; k++) begin
                if (md == 2'b10) begin
                    a[8*k +: 8] = 8'($urandom);
                    b[8*k +: 8] = 8'($urandom);
                end else begin
                    a[8*k +: 8] = 8'(8'h61 + $urandom % 3);
                    b[8*k +: 8] = 8'(8'h61 + $urandom % 3);
                end
            end
            run($sformatf("R%0d random %0d", (md == 2'b00) ? 2 : (md == 2'b01) ? 3 :
                          (md == 2'b10) ? 5 : 4, it),
                a, b, wm, md, int'($urandom % 20), int'($urandom % 20));
        end
        in_valid = 1'b0;
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule